// File: doc/BRIEF.md
# Flux Interval Bucket Classifier

This block sits behind a pulse-interval timer on a double-density floppy read path. Each incoming value is the number of sample-clock ticks between two successive read-data pulses. The block places that value in one of three nominal bins: short (about 4 us, MFM run `10`), middle (about 6 us, run `100`) or long (about 8 us, run `1000`). A value that lands outside all three acceptance windows, including one that falls in a gap between two windows, is marked as a reject. It is never handed to the nearer bin.

Each window has a lower and an upper bound, held in tick units in six registers. Every bound can be rewritten at run time, so the margins can be tuned for a drive or a disk that spins slightly fast. A small sequencer can also load one of two built-in presets. The tight preset uses short 3.2–4.2 us, middle 5.5–6.2 us and long 7.5–8.2 us. The permissive preset widens the middle and long windows downward, to 5.2–6.2 us and 7.2–8.2 us. Preset tick values are derived from the `SAMPLE_MHZ` parameter (ticks = tenths of a microsecond × MHz / 10). At 50 MHz the tight preset is 160–210, 275–310 and 375–410 ticks, and the permissive preset is 160–210, 260–310 and 360–410 ticks.

The bound sequencer has two states. `CFG_IDLE` is the normal state. It moves to `CFG_LOAD` when `preset_req` is high, and it records `preset_sel` as it does so. `CFG_LOAD` writes all six bounds from the recorded preset and always returns to `CFG_IDLE` on the next cycle. Four saturating counters record hits per bin and rejects.

Top module: `flux_interval_classifier`

## Requirements
- R1: After reset, the bounds hold the tight preset, `cfg_legal` is 1, all four counters read 0 and `res_valid` is 0.
- R2: Each cycle with `iv_valid` high produces exactly one result, with `res_valid` high two clock edges later. A cycle without `iv_valid` produces no result.
- R3: Windows are inclusive (lower ≤ ticks ≤ upper). A hit in a window gives `res_code` 0 for short, 1 for middle or 2 for long, with `res_reject` 0.
- R4: A value below the short window, in either gap between windows, or above the long window gives `res_code` 3 with `res_reject` 1.
- R5: `preset_req` high in cycle c, with `preset_sel` 0 (tight) or 1 (permissive), makes the new bounds apply to an interval presented in cycle c+2. A `cfg_we` in cycle c+1 is ignored.
- R6: `cfg_we` writes `cfg_data` to one bound at `cfg_addr`. The map is 0 short lower, 1 short upper, 2 middle lower, 3 middle upper, 4 long lower and 5 long upper. Addresses 6 and 7 change nothing.
- R7: `cfg_legal` is 1 only when each lower bound is at or below its upper bound, short upper < middle lower, and middle upper < long lower. An interval captured while it is 0 always gives code 3.
- R8: Every result increments the counter of its bin, or `rejects` for code 3. The new count is visible in the same cycle as the result.
- R9: Counters saturate at 65535 and do not wrap.
- R10: `cnt_clr` clears all four counters on the next edge, and it overrides an increment landing on that same edge.
- R11: An interval presented in the same cycle as a bound write is judged against the bounds that held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| cfg_we | input | 1 | Bound write strobe |
| cfg_addr | input | 3 | Bound register address |
| cfg_data | input | IV_W (12) | Bound value in ticks |
| preset_req | input | 1 | Start a preset load |
| preset_sel | input | 1 | 0 tight preset, 1 permissive preset |
| iv_valid | input | 1 | Interval present |
| iv_ticks | input | IV_W (12) | Interval length in ticks |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | Bin code (0 short, 1 middle, 2 long, 3 reject) |
| res_reject | output | 1 | Reject flag |
| cfg_legal | output | 1 | Bound set is ordered and consistent |
| hits_short | output | CNT_W (16) | Short-bin hit count |
| hits_mid | output | CNT_W (16) | Middle-bin hit count |
| hits_long | output | CNT_W (16) | Long-bin hit count |
| rejects | output | CNT_W (16) | Reject count |

## Verification
Two pairs of functions can meet on a single clock edge. The first is a counter increment arriving with `cnt_clr`. The bench raises the clear in the cycle just before a pending result is registered, and then expects every counter to read zero rather than one. The second is a bound write issued in the same cycle as an interval. The bench sends 215 ticks while it widens the short upper bound from 210 to 220, and expects a reject for that interval and a short hit for the next one. A preset request followed at once by a stray register write is also judged, through the classification of intervals that only the permissive preset, or only the stray write, would accept.

// File: rtl/flux_cls_pkg.sv
package flux_cls_pkg;

    localparam int NUM_BINS   = 3;
    localparam int NUM_BOUNDS = 2 * NUM_BINS;
    localparam int NUM_CNT    = NUM_BINS + 1;

    typedef enum logic [1:0] {
        BIN_SHORT  = 2'd0,
        BIN_MID    = 2'd1,
        BIN_LONG   = 2'd2,
        BIN_REJECT = 2'd3
    } bin_code_e;

    typedef enum logic {
        CFG_IDLE = 1'b0,
        CFG_LOAD = 1'b1
    } cfg_state_e;

    // Bound in tenths of a microsecond, index order lo/hi per bin.
    function automatic int preset_tenths(input logic permissive, input int idx);
        int t;
        unique case (idx)
            0:       t = 32;
            1:       t = 42;
            2:       t = permissive ? 52 : 55;
            3:       t = 62;
            4:       t = permissive ? 72 : 75;
            default: t = 82;
        endcase
        return t;
    endfunction

    function automatic int tenths_to_ticks(input int tenths, input int mhz);
        return (tenths * mhz) / 10;
    endfunction

endpackage

// File: rtl/flux_bound_regs.sv
module flux_bound_regs
    import flux_cls_pkg::*;
#(
    parameter int IV_W       = 12,
    parameter int SAMPLE_MHZ = 50
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [2:0]                       cfg_addr,
    input  logic [IV_W-1:0]                  cfg_data,
    input  logic                             preset_req,
    input  logic                             preset_sel,
    output logic [NUM_BOUNDS-1:0][IV_W-1:0]  bounds,
    output logic                             cfg_legal
);

    cfg_state_e state_q, state_d;
    logic       sel_q;
    logic       load_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CFG_IDLE && preset_req)
                sel_q <= preset_sel;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: if (preset_req) state_d = CFG_LOAD;
            CFG_LOAD: state_d = CFG_IDLE;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        load_en = 1'b0;
        unique case (state_q)
            CFG_IDLE: load_en = 1'b0;
            CFG_LOAD: load_en = 1'b1;
        endcase
    end

    // Bound register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BOUNDS; i++)
                bounds[i] <= IV_W'(tenths_to_ticks(preset_tenths(1'b0, i), SAMPLE_MHZ));
        end else if (load_en) begin
            for (int i = 0; i < NUM_BOUNDS; i++)
                bounds[i] <= IV_W'(tenths_to_ticks(preset_tenths(sel_q, i), SAMPLE_MHZ));
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_BOUNDS; i++)
                if (cfg_addr == 3'(i))
                    bounds[i] <= cfg_data;
        end
    end

    // Legality: each window well formed, windows strictly ascending
    logic [NUM_BINS-1:0] win_ok;
    logic [NUM_BINS-1:0] order_ok;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_legal
        assign win_ok[b] = bounds[2*b] <= bounds[2*b+1];
        if (b == 0) begin : g_first
            assign order_ok[b] = 1'b1;
        end else begin : g_rest
            assign order_ok[b] = bounds[2*b-1] < bounds[2*b];
        end
    end

    assign cfg_legal = &win_ok & &order_ok;

endmodule

// File: rtl/flux_window_match.sv
module flux_window_match
    import flux_cls_pkg::*;
#(
    parameter int IV_W = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [IV_W-1:0]                  in_ticks,
    input  logic [NUM_BOUNDS-1:0][IV_W-1:0]  bounds,
    input  logic                             legal,
    output logic                             hit_valid,
    output logic [NUM_BINS-1:0]              hit
);

    logic [NUM_BINS-1:0] hit_c;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_win
        assign hit_c[b] = (in_ticks >= bounds[2*b]) && (in_ticks <= bounds[2*b+1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit       <= '0;
        end else begin
            hit_valid <= in_valid;
            hit       <= (in_valid && legal) ? hit_c : '0;
        end
    end

endmodule

// File: rtl/flux_sat_counter.sv
module flux_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/flux_interval_classifier.sv
module flux_interval_classifier
    import flux_cls_pkg::*;
#(
    parameter int IV_W       = 12,
    parameter int CNT_W      = 16,
    parameter int SAMPLE_MHZ = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [IV_W-1:0]  cfg_data,
    input  logic             preset_req,
    input  logic             preset_sel,
    input  logic             iv_valid,
    input  logic [IV_W-1:0]  iv_ticks,
    output logic             res_valid,
    output logic [1:0]       res_code,
    output logic             res_reject,
    output logic             cfg_legal,
    output logic [CNT_W-1:0] hits_short,
    output logic [CNT_W-1:0] hits_mid,
    output logic [CNT_W-1:0] hits_long,
    output logic [CNT_W-1:0] rejects
);

    logic [NUM_BOUNDS-1:0][IV_W-1:0] bounds;
    logic                            s1_valid;
    logic [NUM_BINS-1:0]             s1_hit;
    bin_code_e                       code_c;
    logic [NUM_CNT-1:0]              cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0]   counts;

    flux_bound_regs #(.IV_W(IV_W), .SAMPLE_MHZ(SAMPLE_MHZ)) u_bounds (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .preset_req (preset_req),
        .preset_sel (preset_sel),
        .bounds     (bounds),
        .cfg_legal  (cfg_legal)
    );

    flux_window_match #(.IV_W(IV_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (iv_valid),
        .in_ticks  (iv_ticks),
        .bounds    (bounds),
        .legal     (cfg_legal),
        .hit_valid (s1_valid),
        .hit       (s1_hit)
    );

    // Encode stage-one hits into a bin code
    always_comb begin
        unique casez (s1_hit)
            3'b??1:  code_c = BIN_SHORT;
            3'b?10:  code_c = BIN_MID;
            3'b100:  code_c = BIN_LONG;
            default: code_c = BIN_REJECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_code   <= 2'd0;
            res_reject <= 1'b0;
        end else begin
            res_valid  <= s1_valid;
            res_code   <= s1_valid ? code_c : 2'd0;
            res_reject <= s1_valid && (s1_hit == '0);
        end
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        assign cnt_inc[c] = s1_valid && (code_c == bin_code_e'(c));
        flux_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (cnt_inc[c]),
            .count (counts[c])
        );
    end

    assign hits_short = counts[BIN_SHORT];
    assign hits_mid   = counts[BIN_MID];
    assign hits_long  = counts[BIN_LONG];
    assign rejects    = counts[BIN_REJECT];

endmodule

// File: rtl/flux_classifier_checker.sv
module flux_classifier_checker #(
    parameter int IV_W  = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic             iv_valid,
    input logic             res_valid,
    input logic [1:0]       res_code,
    input logic             res_reject,
    input logic             cfg_legal,
    input logic [CNT_W-1:0] hits_short,
    input logic [CNT_W-1:0] hits_mid,
    input logic [CNT_W-1:0] hits_long,
    input logic [CNT_W-1:0] rejects
);

    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        iv_valid |-> ##2 res_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !iv_valid |-> ##2 !res_valid);

    a_r7_illegal_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_legal && iv_valid) |-> ##2 (res_code == 2'd3 && res_reject));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (rejects == '1 && !cnt_clr) |=> rejects == '1);

    a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> hits_short >= $past(hits_short));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (hits_short == '0 && hits_mid == '0 &&
                     hits_long == '0 && rejects == '0));

endmodule

bind flux_interval_classifier flux_classifier_checker #(
    .IV_W  (IV_W),
    .CNT_W (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_clr    (cnt_clr),
    .iv_valid   (iv_valid),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .res_reject (res_reject),
    .cfg_legal  (cfg_legal),
    .hits_short (hits_short),
    .hits_mid   (hits_mid),
    .hits_long  (hits_long),
    .rejects    (rejects)
);

// File: tb/tb_flux_interval_classifier.sv
module tb_flux_interval_classifier;

    localparam int IV_W  = 12;
    localparam int CNT_W = 16;
    localparam int NVEC  = 16;

    // Tight preset at 50 MHz: short 160..210, middle 275..310, long 375..410
    localparam logic [IV_W-1:0] VEC_T [NVEC] = '{
        12'd159, 12'd160, 12'd185, 12'd210, 12'd211, 12'd274, 12'd275, 12'd300,
        12'd310, 12'd311, 12'd374, 12'd375, 12'd410, 12'd411, 12'd0,   12'd4095
    };
    localparam logic [1:0] VEC_C [NVEC] = '{
        2'd3, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd1,
        2'd1, 2'd3, 2'd3, 2'd2, 2'd2, 2'd3, 2'd3, 2'd3
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_clr = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [IV_W-1:0]  cfg_data = '0;
    logic             preset_req = 1'b0;
    logic             preset_sel = 1'b0;
    logic             iv_valid = 1'b0;
    logic [IV_W-1:0]  iv_ticks = '0;
    logic             res_valid;
    logic [1:0]       res_code;
    logic             res_reject;
    logic             cfg_legal;
    logic [CNT_W-1:0] hits_short, hits_mid, hits_long, rejects;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    flux_interval_classifier dut (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .preset_req(preset_req), .preset_sel(preset_sel),
        .iv_valid(iv_valid), .iv_ticks(iv_ticks),
        .res_valid(res_valid), .res_code(res_code), .res_reject(res_reject),
        .cfg_legal(cfg_legal),
        .hits_short(hits_short), .hits_mid(hits_mid),
        .hits_long(hits_long), .rejects(rejects)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one interval, confirm latency and code (R2, R3, R4)
    task automatic classify(input logic [IV_W-1:0] t, input logic [1:0] exp, input string req);
        iv_valid = 1'b1;
        iv_ticks = t;
        @(negedge clk);
        iv_valid = 1'b0;
        check(res_valid == 1'b0, "R2 early", int'(res_valid), 0);
        @(negedge clk);
        check(res_valid == 1'b1, "R2 valid", int'(res_valid), 1);
        check(res_code == exp, req, int'(res_code), int'(exp));
        check(res_reject == (exp == 2'd3), "R4 flag", int'(res_reject), int'(exp == 2'd3));
    endtask

    task automatic write_bound(input logic [2:0] a, input logic [IV_W-1:0] d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
        check(cfg_legal == 1'b1, "R1 cfg_legal", int'(cfg_legal), 1);
        check(hits_short == 0 && hits_mid == 0 && hits_long == 0 && rejects == 0,
              "R1 counters", int'(hits_short + hits_mid + hits_long + rejects), 0);

        // R3/R4 vector table against the tight preset
        for (int k = 0; k < NVEC; k++)
            classify(VEC_T[k], VEC_C[k], (VEC_C[k] == 2'd3) ? "R4 code" : "R3 code");
        @(negedge clk);
        check(res_valid == 1'b0, "R2 idle", int'(res_valid), 0);

        // R8 counters after the table: 3 short, 3 middle, 2 long, 8 rejects
        check(hits_short == 3, "R8 short", int'(hits_short), 3);
        check(hits_mid == 3, "R8 mid", int'(hits_mid), 3);
        check(hits_long == 2, "R8 long", int'(hits_long), 2);
        check(rejects == 8, "R8 rejects", int'(rejects), 8);

        // R5 permissive preset, with a stray write in the load cycle
        preset_req = 1'b1;
        preset_sel = 1'b1;
        @(negedge clk);
        preset_req = 1'b0;
        write_bound(3'd0, 12'd5);
        classify(12'd260, 2'd1, "R5 permissive mid");
        classify(12'd360, 2'd2, "R5 permissive long");
        classify(12'd100, 2'd3, "R5 stray write ignored");

        // R5 back to tight preset
        preset_req = 1'b1;
        preset_sel = 1'b0;
        @(negedge clk);
        preset_req = 1'b0;
        @(negedge clk);
        classify(12'd260, 2'd3, "R5 tight mid");

        // R6 register writes and ignored addresses
        write_bound(3'd1, 12'd220);
        classify(12'd215, 2'd0, "R6 short upper write");
        write_bound(3'd6, 12'd0);
        write_bound(3'd7, 12'd0);
        check(cfg_legal == 1'b1, "R6 addr 6/7 legal", int'(cfg_legal), 1);
        classify(12'd215, 2'd0, "R6 addr 6/7 ignored");
        classify(12'd0, 2'd3, "R6 addr 6/7 zero not hit");

        // R7 overlap makes the set illegal
        write_bound(3'd1, 12'd300);
        check(cfg_legal == 1'b0, "R7 illegal", int'(cfg_legal), 0);
        classify(12'd185, 2'd3, "R7 forced reject");
        write_bound(3'd2, 12'd376);
        write_bound(3'd3, 12'd375);
        check(cfg_legal == 1'b0, "R7 inverted window", int'(cfg_legal), 0);
        write_bound(3'd2, 12'd275);
        write_bound(3'd3, 12'd310);
        write_bound(3'd1, 12'd210);
        check(cfg_legal == 1'b1, "R7 restored", int'(cfg_legal), 1);

        // R11 write and interval in the same cycle
        iv_valid = 1'b1;
        iv_ticks = 12'd215;
        cfg_we = 1'b1;
        cfg_addr = 3'd1;
        cfg_data = 12'd220;
        @(negedge clk);
        iv_valid = 1'b0;
        cfg_we = 1'b0;
        @(negedge clk);
        check(res_code == 2'd3, "R11 old bound used", int'(res_code), 3);
        classify(12'd215, 2'd0, "R11 new bound used");

        // R10 clear coinciding with an increment
        iv_valid = 1'b1;
        iv_ticks = 12'd185;
        @(negedge clk);
        iv_valid = 1'b0;
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        check(res_valid == 1'b1, "R10 result still given", int'(res_valid), 1);
        check(hits_short == 0, "R10 clear wins", int'(hits_short), 0);
        check(rejects == 0 && hits_mid == 0 && hits_long == 0, "R10 all clear",
              int'(rejects + hits_mid + hits_long), 0);

        // R9 saturation on the short counter
        iv_valid = 1'b1;
        iv_ticks = 12'd185;
        repeat (65540) @(negedge clk);
        iv_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(hits_short == 16'hFFFF, "R9 saturate", int'(hits_short), 65535);
        check(rejects == 0, "R9 others untouched", int'(rejects), 0);

        finish_run();
    end

endmodule